// File: doc/BRIEF.md
# Multiprocessor Kernel Command Front End

This block is the register-mapped entry point through which several processors hand kernel service requests to hardware. Each processor has a private register window. Software first loads two argument registers, for example a task number and a delay. It then writes a command code, and that write is what launches the request. A single order sequencer takes the waiting commands from all processors, one at a time and in round-robin order. It passes each one to a service back end over a plain request/response port and holds that port until the back end answers.

On completion, the processor that issued the command receives a command event. Its result code and return value are captured in its own window, and its interrupt line rises. Independently, a scheduler can post a reschedule event to any processor. That event carries the elected task's control-block pointer, a migration flag and the number of the processor that last ran the task. The target of a reschedule need not be the processor whose command caused it. Each interrupt line stays high until its processor acknowledges the pending event kinds. A read-only global window reports the build configuration.

Top module: `kcmd_front`

## Requirements
- R1: Address bits [7:4] select a window: 0 is the global window, and k (1..NPROC) is the window of processor k-1. Bits [3:0] select a register within a processor window: 0 and 1 are read/write argument registers, 2 is the command register, 3 is status, 4 is the return value, 5 is the reschedule record and 6 is the acknowledge register.
- R2: A command write to a processor with no command outstanding sets status bit 0 (busy). The request is later presented on the back-end port with that processor's command code, both arguments and its index on `svc_proc`.
- R3: At most one request is in flight. `svc_req` stays high with unchanged fields until `svc_done` is seen, and it is low in the following cycle.
- R4: Waiting commands are granted round-robin, starting from the processor after the one granted last. After reset, processor 0 is searched first.
- R5: On completion the busy bit clears and `svc_ret` is stored at offset 4. `svc_err` is stored in status bits [15:8], status bit 1 (command event) is set and the processor's `irq` rises.
- R6: `irq[p]` is the OR of the two pending event bits of processor p and stays high until acknowledged. Writing offset 6 with bit 0 set clears the command event, and with bit 1 set clears the reschedule event. Clearing one leaves the other intact.
- R7: A command write to a busy processor is not dispatched. It puts 0xFF in status bits [15:8] and raises a command event, and the request already in progress continues unchanged.
- R8: A cycle with `sched_valid` high sets status bit 2 (reschedule event) of processor `sched_proc` and raises its `irq`. It also stores the record {migration flag in bit 31, previous processor in bits [23:16], control-block pointer in bits [15:0]} at offset 5.
- R9: The global window returns NPROC at offset 0, NTASK at offset 1 and the service map SVC_MAP at offset 2.
- R10: After reset every `irq` bit is low, `svc_req` is low, and every status and return register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address (window in [7:4], offset in [3:0]) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| svc_req | output | 1 | Request to the service back end is in flight |
| svc_proc | output | PW | Issuing processor of the request |
| svc_cmd | output | DW | Command code |
| svc_p1 | output | DW | First argument |
| svc_p2 | output | DW | Second argument |
| svc_done | input | 1 | Back end finished the request |
| svc_err | input | 8 | Result code from the back end |
| svc_ret | input | DW | Return value from the back end |
| sched_valid | input | 1 | Reschedule event strobe |
| sched_proc | input | PW | Processor that receives the reschedule |
| sched_tcb | input | 16 | Control-block pointer of the elected task |
| sched_migr | input | 1 | Task migrated |
| sched_prev | input | PW | Processor that previously ran the task |
| irq | output | NPROC | Per-processor interrupt lines |

## Verification
The properties assume that the back end raises `svc_done` only while `svc_req` is high. They also assume that `sched_proc` and `sched_prev` always name an existing processor, and that only the bus writes the acknowledge register. The bench back end keeps to these rules. It waits for `svc_req` before it pulses `svc_done` for one cycle, and it drives reschedule strobes only for processors 0 to 2 of the three-processor build. It also stalls the back end on purpose, so that waiting commands pile up and both the round-robin order and the busy rejection can be observed.

// File: rtl/kcmd_front.sv
module kcmd_front #(
  parameter int NPROC   = 2,
  parameter int NTASK   = 8,
  parameter int DW      = 32,
  parameter int SVC_MAP = 32'h0000_003F,
  localparam int PW     = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          svc_req,
  output logic [PW-1:0] svc_proc,
  output logic [DW-1:0] svc_cmd,
  output logic [DW-1:0] svc_p1,
  output logic [DW-1:0] svc_p2,
  input  logic          svc_done,
  input  logic [7:0]    svc_err,
  input  logic [DW-1:0] svc_ret,
  input  logic          sched_valid,
  input  logic [PW-1:0] sched_proc,
  input  logic [15:0]   sched_tcb,
  input  logic          sched_migr,
  input  logic [PW-1:0] sched_prev,
  output logic [NPROC-1:0] irq
);

  localparam logic [7:0] BUSY_CODE = 8'hFF;

  logic [DW-1:0] arg1_q [NPROC];
  logic [DW-1:0] arg2_q [NPROC];
  logic [DW-1:0] code_q [NPROC];
  logic [DW-1:0] ret_q  [NPROC];
  logic [31:0]   rec_q  [NPROC];
  logic [7:0]    res_q  [NPROC];
  logic [NPROC-1:0] wait_q, cev_q, sev_q;

  logic          busy_q;
  logic [PW-1:0] cur_q, rr_q;
  logic          gnt_any;
  logic [PW-1:0] gnt_idx;

  wire [3:0] win = bus_addr[7:4];
  wire [3:0] off = bus_addr[3:0];
  wire       win_ok = (win != 4'd0) && (int'(win) <= NPROC);
  wire [PW-1:0] wsel = PW'(win - 4'd1);
  wire       finish = busy_q && svc_done;

  assign irq     = cev_q | sev_q;
  assign svc_req = busy_q;
  assign svc_proc = cur_q;

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    wire hit    = bus_wr && win_ok && (int'(wsel) == p);
    wire cmd_wr = hit && off == 4'd2;
    wire ack_wr = hit && off == 4'd6;
    wire done_p = finish && (int'(cur_q) == p);
    wire sch_p  = sched_valid && (int'(sched_proc) == p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arg1_q[p] <= '0; arg2_q[p] <= '0; code_q[p] <= '0;
        ret_q[p]  <= '0; rec_q[p]  <= '0; res_q[p]  <= '0;
        wait_q[p] <= 1'b0; cev_q[p] <= 1'b0; sev_q[p] <= 1'b0;
      end else begin
        if (hit && off == 4'd0) arg1_q[p] <= bus_wdata;
        if (hit && off == 4'd1) arg2_q[p] <= bus_wdata;
        if (ack_wr) begin
          if (bus_wdata[0]) cev_q[p] <= 1'b0;
          if (bus_wdata[1]) sev_q[p] <= 1'b0;
        end
        if (cmd_wr) begin
          if (wait_q[p]) begin
            res_q[p] <= BUSY_CODE;
            cev_q[p] <= 1'b1;
          end else begin
            wait_q[p] <= 1'b1;
            code_q[p] <= bus_wdata;
          end
        end
        if (done_p) begin
          wait_q[p] <= 1'b0;
          ret_q[p]  <= svc_ret;
          res_q[p]  <= svc_err;
          cev_q[p]  <= 1'b1;
        end
        if (sch_p) begin
          sev_q[p] <= 1'b1;
          rec_q[p] <= {sched_migr, 7'd0, 8'(sched_prev), sched_tcb};
        end
      end
    end
  end

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = NPROC; k >= 1; k--) begin
      int j;
      j = int'(rr_q) + k;
      if (j >= NPROC) j = j - NPROC;
      if (wait_q[j]) begin
        gnt_any = 1'b1;
        gnt_idx = PW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      rr_q    <= PW'(NPROC - 1);
      svc_cmd <= '0;
      svc_p1  <= '0;
      svc_p2  <= '0;
    end else if (!busy_q) begin
      if (gnt_any) begin
        busy_q  <= 1'b1;
        cur_q   <= gnt_idx;
        rr_q    <= gnt_idx;
        svc_cmd <= code_q[gnt_idx];
        svc_p1  <= arg1_q[gnt_idx];
        svc_p2  <= arg2_q[gnt_idx];
      end
    end else if (svc_done) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (win == 4'd0) begin
      case (off)
        4'd0: bus_rdata = DW'(NPROC);
        4'd1: bus_rdata = DW'(NTASK);
        4'd2: bus_rdata = DW'(SVC_MAP);
        default: bus_rdata = '0;
      endcase
    end else if (win_ok) begin
      case (off)
        4'd0: bus_rdata = arg1_q[wsel];
        4'd1: bus_rdata = arg2_q[wsel];
        4'd3: bus_rdata = DW'({res_q[wsel], 5'd0, sev_q[wsel], cev_q[wsel], wait_q[wsel]});
        4'd4: bus_rdata = ret_q[wsel];
        4'd5: bus_rdata = DW'(rec_q[wsel]);
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/kcmd_front_chk.sv
module kcmd_front_chk #(
  parameter int NPROC = 2,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic             svc_req,
  input logic [PW-1:0]    svc_proc,
  input logic             svc_done,
  input logic             sched_valid,
  input logic [PW-1:0]    sched_proc,
  input logic [NPROC-1:0] irq
);

  assert_hold_inflight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req && !svc_done |=> svc_req && $stable(svc_proc));

  assert_drop_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req && svc_done |=> !svc_req);

  assert_proc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> int'(svc_proc) < NPROC);

  for (genvar p = 0; p < NPROC; p++) begin : g_irq
    localparam logic [7:0] ACK_ADDR = 8'((p + 1) * 16 + 6);

    assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[p]) |-> $past(bus_wr && bus_addr == ACK_ADDR));

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[p]) |-> $past((svc_req && svc_done && int'(svc_proc) == p) ||
                              (sched_valid && int'(sched_proc) == p) || bus_wr));
  end

endmodule

bind kcmd_front kcmd_front_chk #(.NPROC(NPROC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .svc_req(svc_req), .svc_proc(svc_proc), .svc_done(svc_done),
  .sched_valid(sched_valid), .sched_proc(sched_proc), .irq(irq)
);

// File: tb/kcmd_front_bench.sv
module kcmd_front_bench;
  localparam int NP = 3;
  localparam int PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic svc_req, svc_done = 1'b0, sched_valid = 1'b0, sched_migr = 1'b0;
  logic [PW-1:0] svc_proc, sched_proc = '0, sched_prev = '0;
  logic [31:0] svc_cmd, svc_p1, svc_p2, svc_ret = '0;
  logic [7:0] svc_err = '0;
  logic [15:0] sched_tcb = '0;
  logic [NP-1:0] irq;

  int total = 0, bad = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  kcmd_front #(.NPROC(NP), .NTASK(8), .DW(32), .SVC_MAP(32'h3F)) u_kcmd_front (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .svc_req(svc_req),
    .svc_proc(svc_proc), .svc_cmd(svc_cmd), .svc_p1(svc_p1), .svc_p2(svc_p2),
    .svc_done(svc_done), .svc_err(svc_err), .svc_ret(svc_ret),
    .sched_valid(sched_valid), .sched_proc(sched_proc), .sched_tcb(sched_tcb),
    .sched_migr(sched_migr), .sched_prev(sched_prev), .irq(irq));

  localparam int NV = 4;
  localparam int          V_PROC [NV] = '{0, 1, 2, 1};
  localparam logic [31:0] V_CMD  [NV] = '{32'h11, 32'h22, 32'h33, 32'h44};
  localparam logic [31:0] V_A1   [NV] = '{32'd3, 32'd7, 32'd12, 32'd5};
  localparam logic [31:0] V_A2   [NV] = '{32'd100, 32'd0, 32'hABCD, 32'd9};
  localparam logic [31:0] V_RET  [NV] = '{32'hCAFE, 32'd1, 32'h0, 32'h55AA};
  localparam logic [7:0]  V_ERR  [NV] = '{8'd0, 8'd2, 8'd0, 8'd7};

  function automatic logic [7:0] ra(int p, int o);
    return 8'((p + 1) * 16 + o);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_req();
    while (!svc_req) @(negedge clk);
  endtask

  task automatic finish_req(logic [31:0] r, logic [7:0] e);
    svc_done = 1'b1; svc_ret = r; svc_err = e;
    @(negedge clk);
    svc_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", 32'(irq), 32'h0);
    chk("R10 svc_req", 32'(svc_req), 32'h0);
    for (int p = 0; p < NP; p++) begin
      rd(ra(p, 3), rv); chk("R10 status", rv, 32'h0);
      rd(ra(p, 4), rv); chk("R10 ret", rv, 32'h0);
    end

    // R9 global window
    rd(8'h00, rv); chk("R9 nproc", rv, 32'd3);
    rd(8'h01, rv); chk("R9 ntask", rv, 32'd8);
    rd(8'h02, rv); chk("R9 svcmap", rv, 32'h3F);

    // R1 R2 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      wr(ra(V_PROC[v], 0), V_A1[v]);
      wr(ra(V_PROC[v], 1), V_A2[v]);
      rd(ra(V_PROC[v], 0), rv); chk("R1 arg1 readback", rv, V_A1[v]);
      wr(ra(V_PROC[v], 2), V_CMD[v]);
      rd(ra(V_PROC[v], 3), rv); chk("R2 busy", rv & 32'h1, 32'h1);
      wait_req();
      chk("R2 proc", 32'(svc_proc), 32'(V_PROC[v]));
      chk("R2 cmd", svc_cmd, V_CMD[v]);
      chk("R2 arg1", svc_p1, V_A1[v]);
      chk("R2 arg2", svc_p2, V_A2[v]);
      finish_req(V_RET[v], V_ERR[v]);
      chk("R3 req drop", 32'(svc_req), 32'h0);
      chk("R5 irq", 32'(irq[V_PROC[v]]), 32'h1);
      rd(ra(V_PROC[v], 3), rv); chk("R5 status", rv, {16'h0, V_ERR[v], 8'h02});
      rd(ra(V_PROC[v], 4), rv); chk("R5 ret", rv, V_RET[v]);
      wr(ra(V_PROC[v], 6), 32'h1);
      chk("R6 ack clears", 32'(irq), 32'h0);
    end

    // R4 round robin: 1 in flight, then 2 and 0 waiting
    wr(ra(1, 2), 32'h71);
    wait_req();
    chk("R4 first", 32'(svc_proc), 32'd1);
    wr(ra(2, 2), 32'h72);
    wr(ra(0, 2), 32'h70);
    chk("R3 stalled still proc1", 32'(svc_proc), 32'd1);
    finish_req(32'd0, 8'd0);
    wait_req();
    chk("R4 next after 1 is 2", 32'(svc_proc), 32'd2);
    chk("R4 cmd of 2", svc_cmd, 32'h72);
    finish_req(32'd0, 8'd0);
    wait_req();
    chk("R4 then 0", 32'(svc_proc), 32'd0);
    finish_req(32'd0, 8'd0);
    for (int p = 0; p < NP; p++) wr(ra(p, 6), 32'h3);
    chk("R6 all acked", 32'(irq), 32'h0);

    // R7 busy rejection
    wr(ra(0, 2), 32'h80);
    wait_req();
    wr(ra(0, 2), 32'h81);
    rd(ra(0, 3), rv); chk("R7 busy code", rv, 32'hFF03);
    chk("R7 irq", 32'(irq[0]), 32'h1);
    chk("R7 inflight kept", svc_cmd, 32'h80);
    chk("R7 still req", 32'(svc_req), 32'h1);
    wr(ra(0, 6), 32'h1);
    chk("R6 ack during busy", 32'(irq[0]), 32'h0);
    finish_req(32'd4, 8'd0);
    repeat (2) @(negedge clk);
    chk("R7 no redispatch", 32'(svc_req), 32'h0);
    rd(ra(0, 3), rv); chk("R7 final status", rv, 32'h0002);
    wr(ra(0, 6), 32'h1);

    // R8 reschedule on proc 2 with a pending command event there
    wr(ra(2, 2), 32'h90);
    wait_req();
    finish_req(32'd0, 8'd0);
    @(negedge clk);
    sched_valid = 1'b1; sched_proc = 2'd2; sched_tcb = 16'h1234;
    sched_migr = 1'b1; sched_prev = 2'd1;
    @(negedge clk);
    sched_valid = 1'b0;
    rd(ra(2, 5), rv); chk("R8 record", rv, 32'h8001_1234);
    rd(ra(2, 3), rv); chk("R8 status", rv, 32'h0006);
    chk("R8 other procs quiet", 32'(irq[1:0]), 32'h0);
    wr(ra(2, 6), 32'h2);
    chk("R6 cmd event remains", 32'(irq[2]), 32'h1);
    rd(ra(2, 3), rv); chk("R6 status after partial ack", rv, 32'h0002);
    wr(ra(2, 6), 32'h1);
    chk("R6 irq low", 32'(irq[2]), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule